// File: doc/BRIEF.md
# Fuse Array Read Sequencer

This block fetches a run of bytes from a one-time-programmable fuse array. A single start pulse supplies a first address, a byte count, the wanted bank and a burst-mode option. The block first makes sure the array is set to the right bank. It then powers the array up in a fixed order and reads each address through a request/ready handshake with the fuse macro. When the last byte is in, it powers the array back down in the reverse order.

Each byte is delivered on a data output with a one-cycle valid strobe. The end of a run is marked by a one-cycle `done` pulse. Two error flags sit beside `done`: one for a bank that did not take, and one for a macro that never answered. Power timing is taken from the clock frequency parameter, and a divider parameter shortens both the power waits and the ready timeout for simulation.

Top module: `fuse_rd_seq`

## Requirements
- R1: A start with a byte count of zero raises `done` in the cycle after the start edge. It changes no power output, writes no bank and emits no byte.
- R2: When `bank_req` differs from `bank_rb`, the block drives `bank_sel` to `bank_req` before any power step. If `bank_rb` still differs two cycles later, the run ends with `done` and `err_busy` high, with no power step and no byte.
- R3: Power-up runs in this order, each step on a later cycle than the one before: `pg_wmask_dis` rises, `pg_en_a` rises, `pg_en_b` rises at least WAIT_CYC cycles after `pg_en_a`, then `pg_iso` falls.
- R4: Power-down runs in this order, each step on a later cycle than the one before: `pg_iso` rises, `pg_en_b` falls, `pg_en_a` falls at least WAIT_CYC cycles after `pg_en_b`, then `pg_wmask_dis` falls.
- R5: The block emits exactly `byte_cnt` bytes, in address order from `start_addr` upward. Each byte is the `fm_data` value the macro returned for that address, and `dout_vld` is high only while `busy` is high.
- R6: A one-cycle `fm_req` is issued per address only while the array is powered (`pg_iso` low, `pg_en_b` high). The byte is taken when `fm_rdy` is high after that request.
- R7: If `fm_rdy` does not rise within TMO_CYC cycles of a request, no further address is read. The power-down sequence still runs, and `done` then rises with `err_timeout` high.
- R8: With `burst_cfg` high at start, `burst_en` rises after `pg_iso` falls and drops before `pg_iso` rises. With `burst_cfg` low, `burst_en` stays low. `burst_en` is never high while `pg_iso` is high.
- R9: A start pulse while `busy` is high has no effect on the run in progress: no extra bytes, no bank change, and no second run.
- R10: After reset, and on every `done`, the power outputs are in the off state (`pg_iso` high, the other three low) and `burst_en` is low. `busy` is high from the cycle after an accepted non-zero start until `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, sampled only when idle |
| start_addr | input | ADDR_W | First fuse address |
| byte_cnt | input | ADDR_W+1 | Number of bytes to read |
| bank_req | input | 1 | Wanted fuse bank |
| burst_cfg | input | 1 | Enable burst-mode bit during the run |
| bank_sel | output | 1 | Bank select field written by the block |
| bank_rb | input | 1 | Bank select field as read back |
| pg_wmask_dis | output | 1 | Write-mask disable for the power controls |
| pg_en_a | output | 1 | First power enable |
| pg_en_b | output | 1 | Second power enable |
| pg_iso | output | 1 | Isolation toward the core, high = isolated |
| burst_en | output | 1 | Burst-mode bit to the macro |
| fm_req | output | 1 | Read request pulse (ready cleared) |
| fm_addr | output | ADDR_W | Read address to the macro |
| fm_rdy | input | 1 | Macro ready |
| fm_data | input | DATA_W | Macro read data |
| dout | output | DATA_W | Byte output |
| dout_vld | output | 1 | Byte valid strobe |
| done | output | 1 | End-of-run pulse |
| err_busy | output | 1 | Bank switch not confirmed (held until next start) |
| err_timeout | output | 1 | Ready timeout occurred (held until next start) |
| busy | output | 1 | Run in progress |

## Verification
The assertions watch the step order of both power sequences on every cycle. They also confirm that requests and the burst-mode bit appear only while the array is out of isolation, and that `done` always finds the array fully off. Other behaviours need the bench's scenarios to show them. These are the length of the timed waits, the byte values and their address order, the zero-count shortcut, a bank that refuses to switch, a macro that never answers, and a start pulse dropped in the middle of a run.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;

    typedef struct packed {
        logic wmask_dis;
        logic en_a;
        logic en_b;
        logic iso;
    } pwr_ctl_t;

    localparam pwr_ctl_t PWR_OFF_CTL = '{wmask_dis: 1'b0, en_a: 1'b0, en_b: 1'b0, iso: 1'b1};

    typedef enum logic [2:0] {
        PW_OFF, PW_UP1, PW_UPW, PW_UP3, PW_ON, PW_DN1, PW_DNW, PW_DN3
    } pw_state_t;

    typedef enum logic [1:0] {
        RD_IDLE, RD_REQ, RD_WAIT
    } rd_state_t;

    typedef enum logic [2:0] {
        T_IDLE, T_BANK_SET, T_BANK_CHK, T_PWR_UP, T_WAIT, T_PDN, T_PWR_DN
    } top_state_t;

    function automatic int unsigned at_least_one(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

endpackage

// File: rtl/fuse_pwr_seq.sv
module fuse_pwr_seq
    import fuse_rd_pkg::*;
#(
    parameter int unsigned WAIT_CYC = 10
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     up_req,
    input  logic     dn_req,
    output pwr_ctl_t ctl,
    output logic     up_done,
    output logic     dn_done
);
    localparam int unsigned WCW = $clog2(WAIT_CYC + 1);
    localparam logic [WCW-1:0] WLAST = WCW'(WAIT_CYC - 1);

    pw_state_t      st;
    logic [WCW-1:0] wcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= PW_OFF;
            ctl     <= PWR_OFF_CTL;
            wcnt    <= '0;
            up_done <= 1'b0;
            dn_done <= 1'b0;
        end else begin
            up_done <= 1'b0;
            dn_done <= 1'b0;
            case (st)
                PW_OFF: if (up_req) begin
                    ctl.wmask_dis <= 1'b1;
                    st            <= PW_UP1;
                end
                PW_UP1: begin
                    ctl.en_a <= 1'b1;
                    wcnt     <= '0;
                    st       <= PW_UPW;
                end
                PW_UPW: if (wcnt == WLAST) begin
                    ctl.en_b <= 1'b1;
                    st       <= PW_UP3;
                end else begin
                    wcnt <= wcnt + 1'b1;
                end
                PW_UP3: begin
                    ctl.iso <= 1'b0;
                    up_done <= 1'b1;
                    st      <= PW_ON;
                end
                PW_ON: if (dn_req) begin
                    ctl.iso <= 1'b1;
                    st      <= PW_DN1;
                end
                PW_DN1: begin
                    ctl.en_b <= 1'b0;
                    wcnt     <= '0;
                    st       <= PW_DNW;
                end
                PW_DNW: if (wcnt == WLAST) begin
                    ctl.en_a <= 1'b0;
                    st       <= PW_DN3;
                end else begin
                    wcnt <= wcnt + 1'b1;
                end
                PW_DN3: begin
                    ctl.wmask_dis <= 1'b0;
                    dn_done       <= 1'b1;
                    st            <= PW_OFF;
                end
                default: st <= PW_OFF;
            endcase
        end
    end

    // R3: power-up ordering
    p_en_a_after_wmask_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl.en_a) |-> ctl.wmask_dis);
    p_en_b_after_en_a_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl.en_b) |-> (ctl.en_a && ctl.iso));
    p_iso_release_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl.iso) |-> ctl.en_b);
    // R4: power-down ordering
    p_en_b_drop_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl.en_b) |-> ctl.iso);
    p_en_a_drop_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl.en_a) |-> !ctl.en_b);
    p_wmask_drop_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl.wmask_dis) |-> !ctl.en_a);

endmodule

// File: rtl/fuse_byte_rd.sv
module fuse_byte_rd
    import fuse_rd_pkg::*;
#(
    parameter int unsigned ADDR_W  = 11,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned TMO_CYC = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [ADDR_W-1:0] addr,
    output logic              fm_req,
    output logic [ADDR_W-1:0] fm_addr,
    input  logic              fm_rdy,
    input  logic [DATA_W-1:0] fm_data,
    output logic [DATA_W-1:0] byte_q,
    output logic              byte_vld,
    output logic              tmo
);
    localparam int unsigned TCW = $clog2(TMO_CYC + 1);
    localparam logic [TCW-1:0] TLAST = TCW'(TMO_CYC - 1);

    rd_state_t      st;
    logic [TCW-1:0] tcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= RD_IDLE;
            tcnt     <= '0;
            fm_req   <= 1'b0;
            fm_addr  <= '0;
            byte_q   <= '0;
            byte_vld <= 1'b0;
            tmo      <= 1'b0;
        end else begin
            fm_req   <= 1'b0;
            byte_vld <= 1'b0;
            tmo      <= 1'b0;
            case (st)
                RD_IDLE: if (go) begin
                    fm_addr <= addr;
                    fm_req  <= 1'b1;
                    st      <= RD_REQ;
                end
                RD_REQ: begin
                    tcnt <= '0;
                    st   <= RD_WAIT;
                end
                RD_WAIT: if (fm_rdy) begin
                    byte_q   <= fm_data;
                    byte_vld <= 1'b1;
                    st       <= RD_IDLE;
                end else if (tcnt == TLAST) begin
                    tmo <= 1'b1;
                    st  <= RD_IDLE;
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
                default: st <= RD_IDLE;
            endcase
        end
    end

    // R6: request is a single-cycle pulse
    p_req_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        fm_req |=> !fm_req);
    // R7: a byte and a timeout never report together
    p_vld_tmo_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(byte_vld && tmo));

endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq
    import fuse_rd_pkg::*;
#(
    parameter int unsigned ADDR_W      = 11,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned CLK_FREQ_HZ = 250_000_000,
    parameter int unsigned SIM_DIV     = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W:0]   byte_cnt,
    input  logic              bank_req,
    input  logic              burst_cfg,
    output logic              bank_sel,
    input  logic              bank_rb,
    output logic              pg_wmask_dis,
    output logic              pg_en_a,
    output logic              pg_en_b,
    output logic              pg_iso,
    output logic              burst_en,
    output logic              fm_req,
    output logic [ADDR_W-1:0] fm_addr,
    input  logic              fm_rdy,
    input  logic [DATA_W-1:0] fm_data,
    output logic [DATA_W-1:0] dout,
    output logic              dout_vld,
    output logic              done,
    output logic              err_busy,
    output logic              err_timeout,
    output logic              busy
);
    localparam int unsigned CNT_W    = ADDR_W + 1;
    localparam int unsigned WAIT_CYC = at_least_one((CLK_FREQ_HZ / 1000) / SIM_DIV);
    localparam int unsigned TMO_CYC  = at_least_one(CLK_FREQ_HZ / SIM_DIV);

    top_state_t        st;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  rem;
    logic              burst_mode;
    logic              tmo_seen;
    logic              up_req, dn_req, up_done, dn_done;
    logic              go, byte_vld, tmo;
    pwr_ctl_t          pctl;

    fuse_pwr_seq #(.WAIT_CYC(WAIT_CYC)) u_pwr (
        .clk(clk), .rst(rst), .up_req(up_req), .dn_req(dn_req),
        .ctl(pctl), .up_done(up_done), .dn_done(dn_done)
    );

    fuse_byte_rd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TMO_CYC(TMO_CYC)) u_rd (
        .clk(clk), .rst(rst), .go(go), .addr(cur_addr),
        .fm_req(fm_req), .fm_addr(fm_addr), .fm_rdy(fm_rdy), .fm_data(fm_data),
        .byte_q(dout), .byte_vld(byte_vld), .tmo(tmo)
    );

    assign pg_wmask_dis = pctl.wmask_dis;
    assign pg_en_a      = pctl.en_a;
    assign pg_en_b      = pctl.en_b;
    assign pg_iso       = pctl.iso;
    assign dout_vld     = byte_vld;
    assign busy         = (st != T_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= T_IDLE;
            cur_addr    <= '0;
            rem         <= '0;
            burst_mode  <= 1'b0;
            tmo_seen    <= 1'b0;
            bank_sel    <= 1'b0;
            burst_en    <= 1'b0;
            done        <= 1'b0;
            err_busy    <= 1'b0;
            err_timeout <= 1'b0;
            up_req      <= 1'b0;
            dn_req      <= 1'b0;
            go          <= 1'b0;
        end else begin
            done   <= 1'b0;
            up_req <= 1'b0;
            dn_req <= 1'b0;
            go     <= 1'b0;
            case (st)
                T_IDLE: if (start) begin
                    err_busy    <= 1'b0;
                    err_timeout <= 1'b0;
                    tmo_seen    <= 1'b0;
                    cur_addr    <= start_addr;
                    rem         <= byte_cnt;
                    burst_mode  <= burst_cfg;
                    if (byte_cnt == '0) begin
                        done <= 1'b1;
                    end else if (bank_req != bank_rb) begin
                        bank_sel <= bank_req;
                        st       <= T_BANK_SET;
                    end else begin
                        up_req <= 1'b1;
                        st     <= T_PWR_UP;
                    end
                end
                T_BANK_SET: st <= T_BANK_CHK;
                T_BANK_CHK: if (bank_rb == bank_sel) begin
                    up_req <= 1'b1;
                    st     <= T_PWR_UP;
                end else begin
                    err_busy <= 1'b1;
                    done     <= 1'b1;
                    st       <= T_IDLE;
                end
                T_PWR_UP: if (up_done) begin
                    burst_en <= burst_mode;
                    go       <= 1'b1;
                    st       <= T_WAIT;
                end
                T_WAIT: if (byte_vld) begin
                    if (rem == CNT_W'(1)) begin
                        rem <= '0;
                        st  <= T_PDN;
                    end else begin
                        rem      <= rem - CNT_W'(1);
                        cur_addr <= cur_addr + ADDR_W'(1);
                        go       <= 1'b1;
                    end
                end else if (tmo) begin
                    tmo_seen <= 1'b1;
                    st       <= T_PDN;
                end
                T_PDN: begin
                    burst_en <= 1'b0;
                    dn_req   <= 1'b1;
                    st       <= T_PWR_DN;
                end
                T_PWR_DN: if (dn_done) begin
                    done        <= 1'b1;
                    err_timeout <= tmo_seen;
                    st          <= T_IDLE;
                end
                default: st <= T_IDLE;
            endcase
        end
    end

    p_req_powered_r6: assert property (@(posedge clk) disable iff (rst)
        fm_req |-> (!pctl.iso && pctl.en_b));
    p_burst_iso_r8: assert property (@(posedge clk) disable iff (rst)
        burst_en |-> !pctl.iso);
    p_done_off_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> (pctl == PWR_OFF_CTL && !burst_en));
    p_vld_busy_r5: assert property (@(posedge clk) disable iff (rst)
        dout_vld |-> busy);
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(bank_sel));
    p_bank_first_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(pctl.wmask_dis) |-> (bank_sel == bank_rb));

endmodule

// File: tb/test_fuse_rd_seq.sv
module test_fuse_rd_seq;
    localparam int AW    = 11;
    localparam int FREQ  = 250_000_000;
    localparam int DIV   = 25000;
    localparam int WAITC = (FREQ / 1000) / DIV;

    logic clk = 1'b0, rst = 1'b1;
    logic start = 1'b0, bank_req = 1'b0, burst_cfg = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [AW:0]   byte_cnt = '0;
    logic bank_sel, bank_rb, pg_wmask_dis, pg_en_a, pg_en_b, pg_iso, burst_en;
    logic fm_req, fm_rdy, dout_vld, done, err_busy, err_timeout, busy;
    logic [AW-1:0] fm_addr;
    logic [7:0] fm_data, dout;

    always #2 clk = ~clk;

    fuse_rd_seq #(.ADDR_W(AW), .DATA_W(8), .CLK_FREQ_HZ(FREQ), .SIM_DIV(DIV)) i_fuse_rd_seq (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr), .byte_cnt(byte_cnt),
        .bank_req(bank_req), .burst_cfg(burst_cfg), .bank_sel(bank_sel), .bank_rb(bank_rb),
        .pg_wmask_dis(pg_wmask_dis), .pg_en_a(pg_en_a), .pg_en_b(pg_en_b), .pg_iso(pg_iso),
        .burst_en(burst_en), .fm_req(fm_req), .fm_addr(fm_addr), .fm_rdy(fm_rdy),
        .fm_data(fm_data), .dout(dout), .dout_vld(dout_vld), .done(done),
        .err_busy(err_busy), .err_timeout(err_timeout), .busy(busy)
    );

    function automatic logic [7:0] mk_byte(input logic [AW-1:0] a, input logic b);
        return a[7:0] ^ {a[10:8], 5'd0} ^ (b ? 8'hA5 : 8'h3C);
    endfunction

    // fuse macro and bank register model
    bit stuck = 0, lock = 0;
    logic [AW-1:0] m_addr;
    int m_cnt;
    always @(posedge clk) begin
        if (rst) begin
            fm_rdy <= 1'b0; fm_data <= 8'h00; m_cnt <= 0; m_addr <= '0; bank_rb <= 1'b0;
        end else begin
            if (!lock) bank_rb <= bank_sel;
            if (fm_req) begin
                fm_rdy <= 1'b0; m_addr <= fm_addr; m_cnt <= 3;
            end else if (m_cnt > 0) begin
                m_cnt <= m_cnt - 1;
                if (m_cnt == 1 && !stuck) begin
                    fm_rdy <= 1'b1; fm_data <= mk_byte(m_addr, bank_sel);
                end
            end
        end
    end

    int total = 0, bad = 0;
    logic [7:0] exp_q[$];
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // monitor: scoreboard pop and power event stamps
    int cyc = 0, n_bytes = 0;
    int t_wm_r, t_a_r, t_b_r, t_iso_f, t_iso_r, t_b_f, t_a_f, t_wm_f, t_bu_r, t_bu_f;
    bit burst_bad = 0;
    logic p_wm = 0, p_a = 0, p_b = 0, p_iso = 1, p_bu = 0;
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (pg_wmask_dis && !p_wm) t_wm_r = cyc;
            if (!pg_wmask_dis && p_wm) t_wm_f = cyc;
            if (pg_en_a && !p_a) t_a_r = cyc;
            if (!pg_en_a && p_a) t_a_f = cyc;
            if (pg_en_b && !p_b) t_b_r = cyc;
            if (!pg_en_b && p_b) t_b_f = cyc;
            if (!pg_iso && p_iso) t_iso_f = cyc;
            if (pg_iso && !p_iso) t_iso_r = cyc;
            if (burst_en && !p_bu) t_bu_r = cyc;
            if (!burst_en && p_bu) t_bu_f = cyc;
            if (burst_en && pg_iso) burst_bad = 1;
            if (dout_vld) begin
                n_bytes++;
                if (exp_q.size() == 0) chk(0, "R5 unexpected byte", dout, -1);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(dout == e, "R5 byte value", dout, e);
                end
            end
        end
        p_wm = pg_wmask_dis; p_a = pg_en_a; p_b = pg_en_b; p_iso = pg_iso; p_bu = burst_en;
    end

    task automatic clear_marks();
        t_wm_r = -1; t_a_r = -1; t_b_r = -1; t_iso_f = -1; t_iso_r = -1;
        t_b_f = -1; t_a_f = -1; t_wm_f = -1; t_bu_r = -1; t_bu_f = -1;
        n_bytes = 0; burst_bad = 0;
    endtask

    int lat;
    bit got;
    task automatic run(input logic [AW-1:0] a, input int n, input logic b, input logic bc,
                       input bit push, input bit poke);
        clear_marks();
        if (push) for (int i = 0; i < n; i++) exp_q.push_back(mk_byte(a + AW'(i), b));
        @(posedge clk); #1;
        start = 1; start_addr = a; byte_cnt = (AW+1)'(n); bank_req = b; burst_cfg = bc;
        @(posedge clk); #1;
        start = 0;
        if (poke) begin
            repeat (5) @(posedge clk);
            #1; start = 1; start_addr = a + 11'd100; byte_cnt = 12'd7; bank_req = ~b;
            @(posedge clk); #1; start = 0;
        end
        got = 0; lat = -1;
        for (int k = 0; k < 30000 && !got; k++) begin
            @(negedge clk);
            if (done) begin got = 1; lat = k; end
        end
        chk(got, "R10 done seen", got, 1);
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL R10 watchdog act=0 exp=1");
        finish_up();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R10 reset state
        chk(!busy && pg_iso && !pg_en_a && !pg_en_b && !pg_wmask_dis && !burst_en,
            "R10 reset power off", {busy, pg_iso, pg_en_a, pg_en_b, pg_wmask_dis}, 8);
        chk(!done && !bank_sel, "R10 reset done/bank", {done, bank_sel}, 0);

        // R1 zero count, even with a different bank asked
        run(11'h020, 0, 1'b1, 1'b1, 0, 0);
        chk(lat == 0, "R1 immediate done", lat, 0);
        chk(t_wm_r == -1 && n_bytes == 0, "R1 no power, no bytes", n_bytes, 0);
        chk(bank_sel == 1'b0, "R1 no bank write", bank_sel, 0);

        // R5/R3/R4/R8 normal run, bank 0, no burst mode
        run(11'h010, 4, 1'b0, 1'b0, 1, 0);
        chk(n_bytes == 4 && exp_q.size() == 0, "R5 byte count", n_bytes, 4);
        chk(!err_busy && !err_timeout, "R5 no error", {err_busy, err_timeout}, 0);
        chk(t_wm_r > 0 && t_wm_r < t_a_r && t_a_r < t_b_r && t_b_r < t_iso_f, "R3 up order", t_iso_f, t_b_r + 1);
        chk(t_b_r - t_a_r >= WAITC, "R3 up wait", t_b_r - t_a_r, WAITC);
        chk(t_iso_r > t_iso_f && t_iso_r < t_b_f && t_b_f < t_a_f && t_a_f < t_wm_f, "R4 down order", t_wm_f, t_a_f + 1);
        chk(t_a_f - t_b_f >= WAITC, "R4 down wait", t_a_f - t_b_f, WAITC);
        chk(t_bu_r == -1, "R8 burst off when not configured", t_bu_r, -1);
        chk(pg_iso && !pg_wmask_dis && !busy, "R10 off after done", {pg_iso, pg_wmask_dis, busy}, 4);

        // R2 bank switch, top-of-range addresses, R8 burst window
        run(11'h7FE, 2, 1'b1, 1'b1, 1, 0);
        chk(bank_sel == 1'b1, "R2 bank switched", bank_sel, 1);
        chk(n_bytes == 2 && exp_q.size() == 0, "R5 top addresses", n_bytes, 2);
        chk(t_bu_r > t_iso_f && t_bu_f > 0 && t_bu_f < t_iso_r, "R8 burst window", t_bu_r, t_iso_f + 1);
        chk(!burst_bad, "R8 burst never isolated", burst_bad, 0);

        // R2 bank refuses to switch
        lock = 1;
        run(11'h030, 3, 1'b0, 1'b0, 0, 0);
        chk(err_busy && !err_timeout, "R2 busy error", {err_busy, err_timeout}, 2);
        chk(t_wm_r == -1 && n_bytes == 0, "R2 no power on failed bank", n_bytes, 0);
        lock = 0;
        repeat (3) @(posedge clk);

        // R7 macro never ready
        stuck = 1;
        run(11'h100, 3, 1'b0, 1'b0, 0, 0);
        chk(err_timeout && !err_busy, "R7 timeout flag", {err_busy, err_timeout}, 1);
        chk(n_bytes == 0, "R7 no bytes after timeout", n_bytes, 0);
        chk(t_wm_f > t_iso_r && t_iso_r > 0, "R7 power down ran", t_wm_f, t_iso_r + 3);
        stuck = 0;

        // R9 start during busy is dropped
        run(11'h040, 3, 1'b0, 1'b0, 1, 1);
        chk(n_bytes == 3 && exp_q.size() == 0, "R9 only first run bytes", n_bytes, 3);
        chk(bank_sel == 1'b0, "R9 bank unchanged", bank_sel, 0);
        repeat (30) @(negedge clk);
        chk(!busy && n_bytes == 3, "R9 no second run", {busy, 1'b0}, 0);

        finish_up();
    end
endmodule